// File: doc/BRIEF.md
# Sign-Dependent Rounding Saturating Requantizer

This block narrows a wide fixed-point product-sum to a compact fixed-point word. Each input is a 31-bit two's-complement value with 12 integer bits and 18 fraction bits. Each output is a 16-bit two's-complement value with 6 integer bits and 9 fraction bits. It is meant to sit behind a multiply-accumulate array, so that each layer's results become operands for the next layer.

Nine fraction bits are dropped. The rounding rule depends on the sign. A non-negative value is rounded half up on the highest dropped bit. A negative value is truncated, which rounds it toward minus infinity. The integer bits above the output range are then tested. A value that does not fit is clamped to the largest or smallest output code, and an overflow or underflow flag is raised.

The block has one register stage. A value presented with `valid_i` appears on the outputs one clock later, together with its flags.

Top module: `requant_sat`

## Requirements
- R1: `valid_o` equals `valid_i` from the previous clock edge, and the data and flags then shown are those of the value accepted at that edge.
- R2: While `rst_ni` is low, `valid_o`, `data_o`, `ovf_o` and `udf_o` are all zero.
- R3: For a non-negative in-range input x (bit 30 clear), `data_o` equals floor((x+256)/512). The increment is applied exactly when input bit 8 is set.
- R4: For a negative in-range input x (bit 30 set), `data_o` equals floor(x/512). Input bit 8 never causes an increment.
- R5: A non-negative input with any of bits 29:24 set gives `data_o` = 16'h7FFF and `ovf_o` = 1.
- R6: The overflow test is made after rounding. A non-negative input with bits 29:24 clear and bits 23:8 all set gives 16'h7FFF with `ovf_o` = 1.
- R7: A negative input with any of bits 29:24 clear gives `data_o` = 16'h8000 and `udf_o` = 1.
- R8: Output bit 15 equals input bit 30 for every accepted value.
- R9: While `valid_i` is low, `data_o`, `ovf_o` and `udf_o` keep their previous values, whatever `data_i` carries.
- R10: `ovf_o` and `udf_o` are never both set. Both are clear for a value that needed no clamping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input value present |
| data_i | input | 31 | Signed product-sum, 18 fraction bits |
| valid_o | output | 1 | Output value present |
| data_o | output | 16 | Requantized signed value, 9 fraction bits |
| ovf_o | output | 1 | Output was clamped to the top code |
| udf_o | output | 1 | Output was clamped to the bottom code |

## Verification
The bench targets several boundary cases:
- Values on the rounding boundary of both signs (255, 256, -256, -513). A design that rounds negatives, or rounds on the wrong bit, is off by one LSB there.
- The positive input whose rounding carries into bit 24. A design that tests the range before rounding wraps this value to 16'h8000 instead of clamping it.
- The edges of the negative range: -2^24 must pass as 16'h8000 with no flag, and one LSB below it must underflow. Swapped or shifted range bits give the wrong flag at one of these two points.
- Invalid cycles carrying garbage data. A design whose output register loads unconditionally corrupts the held word.

// File: rtl/requant_pkg.sv
package requant_pkg;
  parameter int unsigned IN_W_DEF     = 31;
  parameter int unsigned IN_FRAC_DEF  = 18;
  parameter int unsigned OUT_W_DEF    = 16;
  parameter int unsigned OUT_FRAC_DEF = 9;

  typedef enum logic [1:0] {
    SAT_NONE = 2'd0,
    SAT_HIGH = 2'd1,
    SAT_LOW  = 2'd2
  } sat_e;
endpackage

// File: rtl/requant_round.sv
// Drops DROP fraction bits; rounds half up only when the value is non-negative.
module requant_round #(
  parameter int unsigned IN_W  = 31,
  parameter int unsigned DROP  = 9,
  parameter int unsigned MAG_W = 15,
  localparam int unsigned HI_W   = IN_W - 1 - DROP - MAG_W,
  localparam int unsigned BODY_W = HI_W + MAG_W + 1
) (
  input  logic [IN_W-1:0]   x_i,
  output logic              neg_o,
  output logic [BODY_W-1:0] body_o
);
  logic [BODY_W-2:0] trunc;
  assign trunc = x_i[IN_W-2:DROP];
  assign neg_o = x_i[IN_W-1];

  generate
    if (DROP > 0) begin : g_rnd
      logic inc;
      assign inc    = ~x_i[IN_W-1] & x_i[DROP-1];
      assign body_o = {1'b0, trunc} + BODY_W'(inc);
      if (DROP > 1) begin : g_lo
        logic unused_lo;
        assign unused_lo = ^x_i[DROP-2:0];
      end
    end else begin : g_norm
      assign body_o = {1'b0, trunc};
    end
  endgenerate
endmodule

// File: rtl/requant_clamp.sv
// Range test on the bits above the output magnitude, per sign.
module requant_clamp
  import requant_pkg::*;
#(
  parameter int unsigned OUT_W = 16,
  parameter int unsigned HI_W  = 6,
  localparam int unsigned MAG_W  = OUT_W - 1,
  localparam int unsigned BODY_W = HI_W + MAG_W + 1
) (
  input  logic              neg_i,
  input  logic [BODY_W-1:0] body_i,
  output logic [OUT_W-1:0]  data_o,
  output sat_e              sat_o
);
  logic [HI_W:0]   hi_pos;
  logic [HI_W-1:0] hi_neg;
  assign hi_pos = body_i[BODY_W-1:MAG_W];
  assign hi_neg = body_i[BODY_W-2:MAG_W];

  always_comb begin
    if (!neg_i) begin
      if (|hi_pos) begin
        sat_o  = SAT_HIGH;
        data_o = {1'b0, {MAG_W{1'b1}}};
      end else begin
        sat_o  = SAT_NONE;
        data_o = {1'b0, body_i[MAG_W-1:0]};
      end
    end else begin
      if (!(&hi_neg)) begin
        sat_o  = SAT_LOW;
        data_o = {1'b1, {MAG_W{1'b0}}};
      end else begin
        sat_o  = SAT_NONE;
        data_o = {1'b1, body_i[MAG_W-1:0]};
      end
    end
  end
endmodule

// File: rtl/requant_stage.sv
module requant_stage
  import requant_pkg::*;
#(
  parameter int unsigned OUT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [OUT_W-1:0] data_i,
  input  sat_e             sat_i,
  output logic             valid_o,
  output logic [OUT_W-1:0] data_o,
  output logic             ovf_o,
  output logic             udf_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      ovf_o   <= 1'b0;
      udf_o   <= 1'b0;
    end else begin
      valid_o <= en_i;
      if (en_i) begin
        data_o <= data_i;
        ovf_o  <= (sat_i == SAT_HIGH);
        udf_o  <= (sat_i == SAT_LOW);
      end
    end
  end
endmodule

// File: rtl/requant_sat.sv
module requant_sat
  import requant_pkg::*;
#(
  parameter int unsigned IN_W     = IN_W_DEF,
  parameter int unsigned IN_FRAC  = IN_FRAC_DEF,
  parameter int unsigned OUT_W    = OUT_W_DEF,
  parameter int unsigned OUT_FRAC = OUT_FRAC_DEF,
  localparam int unsigned DROP   = IN_FRAC - OUT_FRAC,
  localparam int unsigned MAG_W  = OUT_W - 1,
  localparam int unsigned HI_W   = IN_W - 1 - DROP - MAG_W,
  localparam int unsigned BODY_W = HI_W + MAG_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [IN_W-1:0]  data_i,
  output logic             valid_o,
  output logic [OUT_W-1:0] data_o,
  output logic             ovf_o,
  output logic             udf_o
);
  logic              neg;
  logic [BODY_W-1:0] body;
  logic [OUT_W-1:0]  clamped;
  sat_e              sat;

  requant_round #(.IN_W(IN_W), .DROP(DROP), .MAG_W(MAG_W)) i_round (
    .x_i   (data_i),
    .neg_o (neg),
    .body_o(body)
  );

  requant_clamp #(.OUT_W(OUT_W), .HI_W(HI_W)) i_clamp (
    .neg_i (neg),
    .body_i(body),
    .data_o(clamped),
    .sat_o (sat)
  );

  requant_stage #(.OUT_W(OUT_W)) i_stage (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (valid_i),
    .data_i (clamped),
    .sat_i  (sat),
    .valid_o(valid_o),
    .data_o (data_o),
    .ovf_o  (ovf_o),
    .udf_o  (udf_o)
  );
endmodule

// File: rtl/requant_sat_chk.sv
module requant_sat_chk #(
  parameter int unsigned IN_W  = 31,
  parameter int unsigned OUT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [IN_W-1:0]  data_i,
  input logic             valid_o,
  input logic [OUT_W-1:0] data_o,
  input logic             ovf_o,
  input logic             udf_o
);
  localparam logic [OUT_W-1:0] TOP = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] BOT = {1'b1, {(OUT_W-1){1'b0}}};

  // R1
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R1
  idle_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R5
  ovf_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> data_o == TOP);
  // R7
  udf_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    udf_o |-> data_o == BOT);
  // R8
  sign_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> data_o[OUT_W-1] == $past(data_i[IN_W-1]));
  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o) && $stable(ovf_o) && $stable(udf_o));
  // R10
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ovf_o && udf_o));
endmodule

bind requant_sat requant_sat_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) i_chk (.*);

// File: tb/test_requant_sat.sv
`timescale 1ns/1ps
module test_requant_sat;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [30:0] data_i = '0;
  logic        valid_o;
  logic [15:0] data_o;
  logic        ovf_o;
  logic        udf_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic        m_valid = 0;
  logic [15:0] m_data = 0;
  logic        m_ovf = 0, m_udf = 0, m_sign = 0;
  string       m_tag = "R2";

  always #10 clk_i = ~clk_i;

  requant_sat i_requant_sat (.*);

  function automatic void model(input logic [30:0] d, output logic [15:0] q16,
                                output logic ov, output logic un, output string tag);
    longint x, q;
    x = {{33{d[30]}}, d};
    q = (x < 0) ? (x >>> 9) : ((x + 256) >>> 9);
    ov = q > 32767;
    un = q < -32768;
    if (ov) q = 32767;
    if (un) q = -32768;
    q16 = q[15:0];
    if (ov) tag = (d[29:24] == 0) ? "R6" : "R5";
    else if (un) tag = "R7";
    else if (d[30]) tag = "R4";
    else tag = "R3";
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic v, input logic [30:0] d);
    logic [15:0] q;
    logic ov, un;
    string tg;
    @(negedge clk_i);
    chk("R1", {31'd0, valid_o}, {31'd0, m_valid});
    chk(m_tag, {14'd0, ovf_o, udf_o, data_o}, {14'd0, m_ovf, m_udf, m_data});
    if (m_valid) begin
      chk("R8", {31'd0, data_o[15]}, {31'd0, m_sign});
      chk("R10", {31'd0, ovf_o & udf_o}, 32'd0);
    end
    valid_i = v;
    data_i  = d;
    m_valid = v;
    if (v) begin
      model(d, q, ov, un, tg);
      m_data = q; m_ovf = ov; m_udf = un; m_sign = d[30]; m_tag = tg;
    end else begin
      m_tag = "R9";
    end
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    @(negedge clk_i);
    // R2: reset state
    chk("R2", {15'd0, valid_o, data_o}, 32'd0);
    chk("R2", {30'd0, ovf_o, udf_o}, 32'd0);
    rst_ni = 1'b1;
    step(1, 31'd0);
    step(1, 31'd255);             // R3 below half
    step(1, 31'd256);             // R3 half rounds up
    step(1, 31'd511);
    step(1, 31'd512);
    step(1, 31'h00FFFE00);        // R3 top code, no flag
    step(1, 31'h00FFFF00);        // R6 carry into bit 24
    step(1, 31'h01000000);        // R5
    step(1, 31'h3FFFFFFF);        // R5
    step(1, -31'sd1);             // R4
    step(1, -31'sd256);           // R4 no increment
    step(1, -31'sd513);
    step(1, -31'sd16777216);      // R4 bottom code, no flag
    step(1, -31'sd16777217);      // R7
    step(1, 31'h40000000);        // R7
    step(0, 31'h12345678);        // R9 garbage while idle
    step(0, 31'h7FFFFFFF);        // R9
    step(1, 31'h00000300);
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r, t;
      logic [30:0] d;
      r = $urandom;
      t = $urandom;
      case (r[2:0])
        3'd0: d = t[30:0];
        3'd1, 3'd2: d = {{6{t[24]}}, t[24:0]};
        3'd3: d = {t[30], {6{~t[30]}} ^ {5'd0, t[5]}, 8'hFF, 8'hFF, t[16:8]};
        default: d = {{10{t[20]}}, t[20:0]};
      endcase
      step(r[7:4] != 0, d);
    end
    step(0, 31'd0);
    step(0, 31'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule